// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Sequencer

This block is the bus-master side of an indivisible read-modify-write transfer on an asynchronous, handshake-terminated bus. The sequencer holds the address strobe for one unbroken tenure. Within that tenure it runs a read, hands the captured word to an internal modify port, and then writes the modified word back. The strobes, the read/write line and the data-bus output enable are registered. They are stepped through numbered states, S0 to S19, one state per cycle of the block clock. The block clock runs at twice the bus clock, so each state is half a bus clock.

The responder ends each data phase by asserting an acknowledge, a bus error, or both. The sequencer samples the handshake only in the two check states and only on whole-bus-clock boundaries, so each wait it inserts is an even number of states. There are three ways a transfer can end. A normal ending completes both portions. Acknowledge together with bus error in the read phase abandons the write at a fixed point. Bus error alone in the read phase abandons the transfer at a different fixed point. Each of the two error endings raises a registered error flag.

Top module: `rmw_bus_seq`

## Requirements
- R1: Out of reset and whenever idle, the address strobe, both byte strobes and the data strobe are low, read/write is high (read), the output enable is low, and error is low.
- R2: A start request in idle enters S0 on the next clock. The address strobe rises in S2 and, on a normal transfer, stays high without a gap across the read and write portions through S18. It falls in S19.
- R3: In the read portion, the data strobe and the selected byte strobes are high from S2 through S6 and drop in S7. Byte strobes are selected by upper (bit 15..8) and lower (bit 7..0) lane inputs latched at start. Read/write stays high and the output enable stays low.
- R4: In S4 and S16, the handshake is sampled only on the first state of each bus clock. While neither acknowledge nor error is seen, the sequencer stays in that state for whole bus clocks (two states each) and all outputs hold.
- R5: On a normal read, the data input sampled at the end of S6 appears on the modify read port with a valid pulse of exactly one cycle during S7.
- R6: In the write portion, read/write goes low in S14. The output enable turns on in S15 with the modify-port write data captured on entry to S15. The data and byte strobes rise in S16 and hold through S17 and S18. Address and data strobes fall together in S19. Read/write returns high and the output enable turns off on the following edge.
- R7: If acknowledge and bus error are seen together in S4, no modify valid pulse is given and the data strobes drop in S7. The address strobe holds through S10 and drops in S11. The transfer then ends with error set, and read/write never goes low.
- R8: If bus error alone is seen in S4, the data strobes hold through S8 and drop in S9. The address strobe holds through S10. The transfer ends after S10 with error set.
- R9: An acknowledge in S16 ends the write normally whether or not bus error comes with it, and error stays low.
- R10: The done output pulses for one cycle in the first idle cycle after a transfer. The error flag stays set until the next accepted start, which clears it on entry to S0.
- R11: Start requests and changes of the lane select inputs during a transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two states per bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (sampled in idle) |
| upper_i | input | 1 | Enable upper byte lane |
| lower_i | input | 1 | Enable lower byte lane |
| ack_i | input | 1 | Transfer acknowledge from responder |
| berr_i | input | 1 | Bus error from responder |
| data_i | input | DATA_W | Read data from the bus |
| mod_wdata_i | input | DATA_W | Modified word to write back |
| as_o | output | 1 | Address strobe, active high |
| uds_o | output | 1 | Upper byte strobe |
| lds_o | output | 1 | Lower byte strobe |
| ds_o | output | 1 | Data strobe |
| rw_o | output | 1 | High read, low write |
| oe_o | output | 1 | Data-bus output enable |
| wdata_o | output | DATA_W | Write data driven while enabled |
| mod_rdata_o | output | DATA_W | Captured read word for the modifier |
| mod_valid_o | output | 1 | One-cycle pulse marking mod_rdata_o |
| err_o | output | 1 | Set by an error ending |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situation to reach from the ports is a handshake that arrives on the correct half of the bus clock after a chosen number of wait periods, with a given mix of acknowledge and error. A handshake one state early or late either goes unseen or produces a different ending. The driver task builds the full expected state list for each transfer from its wait counts and ending kind. It computes the index of the last check state from that list and raises the handshake only in the cycle that precedes the sampling edge. The scoreboard then compares every output on every cycle, so a strobe edge that moves by one state is reported against its requirement.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;
  localparam int unsigned STEP_W = 5;
  localparam int unsigned LANES  = 2;

  typedef enum logic [1:0] {
    PATH_OK   = 2'd0,
    PATH_BOTH = 2'd1,
    PATH_BERR = 2'd2
  } path_e;

  // state numbers whose position drives behaviour
  localparam logic [STEP_W-1:0] ST_AS_ON       = 5'd2;
  localparam logic [STEP_W-1:0] ST_RD_CHK      = 5'd4;
  localparam logic [STEP_W-1:0] ST_RD_SAMPLE   = 5'd6;
  localparam logic [STEP_W-1:0] ST_RD_DS_OFF   = 5'd7;
  localparam logic [STEP_W-1:0] ST_BERR_DS_OFF = 5'd9;
  localparam logic [STEP_W-1:0] ST_BERR_END    = 5'd10;
  localparam logic [STEP_W-1:0] ST_BOTH_END    = 5'd11;
  localparam logic [STEP_W-1:0] ST_WR_RW_LOW   = 5'd14;
  localparam logic [STEP_W-1:0] ST_WR_DRIVE    = 5'd15;
  localparam logic [STEP_W-1:0] ST_WR_CHK      = 5'd16;
  localparam logic [STEP_W-1:0] ST_WR_END      = 5'd19;
endpackage

// File: rtl/rmw_wait_gate.sv
module rmw_wait_gate (
  input  logic check_i,
  input  logic hs_i,
  input  logic half_i,
  output logic adv_o,
  output logic half_d_o
);
  // handshake is only looked at on the first half of a bus clock
  always_comb begin
    adv_o    = !check_i || (!half_i && hs_i);
    half_d_o = (check_i && !adv_o) ? !half_i : 1'b0;
  end
endmodule

// File: rtl/rmw_strobe_decode.sv
module rmw_strobe_decode
  import rmw_seq_pkg::*;
(
  input  logic              busy_i,
  input  logic [STEP_W-1:0] step_i,
  input  path_e             path_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic              as_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              oe_o,
  output logic [LANES-1:0]  lane_stb_o
);
  logic wr_path;
  logic rd_stb;
  logic wr_stb;
  logic as_hold;
  logic [STEP_W-1:0] rd_off;

  always_comb begin
    wr_path = (path_i == PATH_OK);
    rd_off  = (path_i == PATH_BERR) ? ST_BERR_DS_OFF : ST_RD_DS_OFF;
    case (path_i)
      PATH_OK:   as_hold = step_i < ST_WR_END;
      PATH_BOTH: as_hold = step_i < ST_BOTH_END;
      default:   as_hold = 1'b1;
    endcase
    rd_stb = (step_i >= ST_AS_ON) && (step_i < rd_off);
    wr_stb = wr_path && (step_i >= ST_WR_CHK) && (step_i < ST_WR_END);
    as_o   = busy_i && (step_i >= ST_AS_ON) && as_hold;
    ds_o   = busy_i && (rd_stb || wr_stb);
    rw_o   = !(busy_i && wr_path && (step_i >= ST_WR_RW_LOW));
    oe_o   = busy_i && wr_path && (step_i >= ST_WR_DRIVE);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_stb_o[g] = ds_o & lane_en_i[g];
  end
endmodule

// File: rtl/rmw_data_latch.sv
module rmw_data_latch #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_rd_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] mod_wdata_i,
  output logic [DATA_W-1:0] mod_rdata_o,
  output logic              mod_valid_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mod_rdata_o <= '0;
      mod_valid_o <= 1'b0;
      wdata_o     <= '0;
    end else begin
      mod_valid_o <= cap_rd_i;
      if (cap_rd_i)  mod_rdata_o <= data_i;
      if (load_wr_i) wdata_o     <= mod_wdata_i;
    end
  end
endmodule

// File: rtl/rmw_bus_seq.sv
module rmw_bus_seq
  import rmw_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              upper_i,
  input  logic              lower_i,
  input  logic              ack_i,
  input  logic              berr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] mod_wdata_i,
  output logic              as_o,
  output logic              uds_o,
  output logic              lds_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] mod_rdata_o,
  output logic              mod_valid_o,
  output logic              err_o,
  output logic              done_o
);
  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d, last_step;
  path_e             path_q, path_d;
  logic [LANES-1:0]  lane_q, lane_d;
  logic              half_q, half_d;
  logic              chk_state, adv, finish;
  logic              as_n, ds_n, rw_n, oe_n;
  logic [LANES-1:0]  stb_n;
  logic              cap_rd, load_wr;

  assign chk_state = busy_q && (step_q == ST_RD_CHK || step_q == ST_WR_CHK);

  rmw_wait_gate u_wait (
    .check_i  (chk_state),
    .hs_i     (ack_i | berr_i),
    .half_i   (half_q),
    .adv_o    (adv),
    .half_d_o (half_d)
  );

  always_comb begin
    case (path_q)
      PATH_OK:   last_step = ST_WR_END;
      PATH_BOTH: last_step = ST_BOTH_END;
      default:   last_step = ST_BERR_END;
    endcase
    finish = busy_q && adv && (step_q == last_step);

    busy_d = busy_q;
    step_d = step_q;
    path_d = path_q;
    lane_d = lane_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        step_d = '0;
        path_d = PATH_OK;
        lane_d = {upper_i, lower_i};
      end
    end else if (adv) begin
      if (step_q == last_step) busy_d = 1'b0;
      else                     step_d = step_q + 5'd1;
      if (step_q == ST_RD_CHK)
        path_d = ack_i ? (berr_i ? PATH_BOTH : PATH_OK) : PATH_BERR;
    end
  end

  // outputs are registered from the decode of the next state
  rmw_strobe_decode u_dec (
    .busy_i     (busy_d),
    .step_i     (step_d),
    .path_i     (path_d),
    .lane_en_i  (lane_d),
    .as_o       (as_n),
    .ds_o       (ds_n),
    .rw_o       (rw_n),
    .oe_o       (oe_n),
    .lane_stb_o (stb_n)
  );

  assign cap_rd  = busy_q && (path_q == PATH_OK) && (step_q == ST_RD_SAMPLE) && adv;
  assign load_wr = busy_d && (step_d == ST_WR_DRIVE) && (step_q != ST_WR_DRIVE);

  rmw_data_latch #(.DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst         (rst),
    .cap_rd_i    (cap_rd),
    .data_i      (data_i),
    .load_wr_i   (load_wr),
    .mod_wdata_i (mod_wdata_i),
    .mod_rdata_o (mod_rdata_o),
    .mod_valid_o (mod_valid_o),
    .wdata_o     (wdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
      path_q <= PATH_OK;
      lane_q <= '0;
      half_q <= 1'b0;
      as_o   <= 1'b0;
      uds_o  <= 1'b0;
      lds_o  <= 1'b0;
      ds_o   <= 1'b0;
      rw_o   <= 1'b1;
      oe_o   <= 1'b0;
      err_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      path_q <= path_d;
      lane_q <= lane_d;
      half_q <= half_d;
      as_o   <= as_n;
      uds_o  <= stb_n[1];
      lds_o  <= stb_n[0];
      ds_o   <= ds_n;
      rw_o   <= rw_n;
      oe_o   <= oe_n;
      done_o <= finish;
      if (!busy_q && start_i)              err_o <= 1'b0;
      else if (finish && path_q != PATH_OK) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rmw_bus_seq_chk.sv
module rmw_bus_seq_chk
  import rmw_seq_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  as_o,
  input logic  ds_o,
  input logic  rw_o,
  input logic  oe_o,
  input logic  mod_valid_o,
  input logic  err_o,
  input logic  done_o,
  input logic  busy_q,
  input path_e path_q,
  input logic  chk_state,
  input logic  adv
);
  a_r1_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!as_o && !ds_o && rw_o && !oe_o));

  a_r6_ds_inside_as: assert property (@(posedge clk) disable iff (rst)
    ds_o |-> as_o);

  a_r6_oe_only_writing: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> !rw_o);

  a_r7_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
    (busy_q && path_q != PATH_OK) |-> (rw_o && !oe_o));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    mod_valid_o |=> !mod_valid_o);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> done_o);

  a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && chk_state && !adv) |=> ($stable(as_o) && $stable(ds_o) && $stable(rw_o)));
endmodule

bind rmw_bus_seq rmw_bus_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .as_o        (as_o),
  .ds_o        (ds_o),
  .rw_o        (rw_o),
  .oe_o        (oe_o),
  .mod_valid_o (mod_valid_o),
  .err_o       (err_o),
  .done_o      (done_o),
  .busy_q      (busy_q),
  .path_q      (path_q),
  .chk_state   (chk_state),
  .adv         (adv)
);

// File: tb/rmw_bus_seq_tb.sv
`timescale 1ns/1ps
module rmw_bus_seq_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, upper_i = 0, lower_i = 0, ack_i = 0, berr_i = 0;
  logic [DW-1:0] data_i = '0, mod_wdata_i = '0;
  logic as_o, uds_o, lds_o, ds_o, rw_o, oe_o, mod_valid_o, err_o, done_o;
  logic [DW-1:0] wdata_o, mod_rdata_o;

  always #2.5 clk = ~clk;

  rmw_bus_seq #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .upper_i(upper_i), .lower_i(lower_i),
    .ack_i(ack_i), .berr_i(berr_i), .data_i(data_i), .mod_wdata_i(mod_wdata_i),
    .as_o(as_o), .uds_o(uds_o), .lds_o(lds_o), .ds_o(ds_o), .rw_o(rw_o), .oe_o(oe_o),
    .wdata_o(wdata_o), .mod_rdata_o(mod_rdata_o), .mod_valid_o(mod_valid_o),
    .err_o(err_o), .done_o(done_o)
  );

  typedef struct {
    logic [8:0]    vec;   // as uds lds ds rw oe mv err done
    logic [DW-1:0] rd;
    int            tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  // codes 0..19 are states, 30 first idle (done), 31 later idle
  function automatic logic [8:0] exp_vec(int c, int k, logic u, logic l);
    logic wr, a, s, r, o, m, e, d;
    wr = (k == 0 || k == 3);
    if (c >= 30) begin
      a = 0; s = 0; r = 1; o = 0; m = 0; d = (c == 30); e = (k == 1 || k == 2);
    end else begin
      a = (c >= 2) && (wr ? c <= 18 : c <= 10);
      s = (c >= 2 && c <= (k == 2 ? 8 : 6)) || (wr && c >= 16 && c <= 18);
      r = !(wr && c >= 14);
      o = wr && c >= 15;
      m = wr && c == 7;
      e = 0; d = 0;
    end
    return {a, s & u, s & l, s, r, o, m, e, d};
  endfunction

  function automatic int tag_of(int c, int k, bit mid);
    if (mid)    return 11;
    if (c == 30 || c == 0) return 10;
    if (c == 31) return 1;
    if (k == 1) return 7;
    if (k == 2) return 8;
    if (k == 3) return 9;
    if (c == 4) return 4;
    if (c <= 7) return 3;
    if (c >= 12) return 6;
    return 2;
  endfunction

  // driver: pushes the expected output of the state entered at the next edge
  task automatic run_txn(input int k, input logic u, input logic l, input int rwt,
                         input int wwt, input bit mid, input logic [DW-1:0] rd);
    int codes[$];
    int idx_r, idx_w;
    exp_t e;
    for (int c = 0; c < 4; c++) codes.push_back(c);
    for (int w = 0; w < 1 + 2*rwt; w++) codes.push_back(4);
    if (k == 0 || k == 3) begin
      for (int c = 5; c < 16; c++) codes.push_back(c);
      for (int w = 0; w < 1 + 2*wwt; w++) codes.push_back(16);
      codes.push_back(17); codes.push_back(18); codes.push_back(19);
    end else begin
      for (int c = 5; c <= (k == 1 ? 11 : 10); c++) codes.push_back(c);
    end
    codes.push_back(30);
    idx_r = 4 + 2*rwt;
    idx_w = 16 + 2*rwt + 2*wwt;
    for (int j = 0; j < codes.size(); j++) begin
      @(negedge clk);
      start_i     = (j == 0) || (mid && j == 6);
      upper_i     = (mid && j == 6) ? ~u : u;
      lower_i     = (mid && j == 6) ? ~l : l;
      data_i      = rd;
      mod_wdata_i = ~rd;
      ack_i = 0; berr_i = 0;
      if (j == idx_r + 1) begin
        ack_i  = (k != 2);
        berr_i = (k == 1 || k == 2);
      end
      if ((k == 0 || k == 3) && j == idx_w + 1) begin
        ack_i  = 1;
        berr_i = (k == 3);
      end
      e.vec = exp_vec(codes[j], k, u, l);
      e.rd  = rd;
      e.tag = tag_of(codes[j], k, mid);
      exp_q.push_back(e);
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      start_i = 0; ack_i = 0; berr_i = 0;
      e.vec = exp_vec(31, k, u, l);
      e.rd  = rd;
      e.tag = 1;
      exp_q.push_back(e);
    end
  endtask

  // monitor: compares one expected item per clock, 1 ns after the edge
  initial begin
    exp_t e;
    logic [8:0] got;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e   = exp_q.pop_front();
        got = {as_o, uds_o, lds_o, ds_o, rw_o, oe_o, mod_valid_o, err_o, done_o};
        checks++;
        if (got !== e.vec) begin
          fails++;
          $display("FAIL %s outputs got=%b exp=%b", tag_name(e.tag), got, e.vec);
        end
        if (e.vec[2]) begin
          checks++;
          if (mod_rdata_o !== e.rd) begin
            fails++;
            $display("FAIL R5 mod_rdata got=%h exp=%h", mod_rdata_o, e.rd);
          end
        end
        if (e.vec[3]) begin
          checks++;
          if (wdata_o !== ~e.rd) begin
            fails++;
            $display("FAIL R6 wdata got=%h exp=%h", wdata_o, ~e.rd);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired got=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;  // R1 reset state
    if ({as_o, uds_o, lds_o, ds_o, rw_o, oe_o, err_o, done_o} !== 8'b0000_1000) begin
      fails++;
      $display("FAIL R1 reset got=%b exp=%b",
               {as_o, uds_o, lds_o, ds_o, rw_o, oe_o, err_o, done_o}, 8'b0000_1000);
    end
    run_txn(0, 1'b1, 1'b0, 0, 0, 1'b0, 16'hA55A);  // R2 R3 R5 R6 plain
    run_txn(0, 1'b1, 1'b1, 2, 1, 1'b0, 16'h1234);  // R4 waits in both phases
    run_txn(1, 1'b0, 1'b1, 1, 0, 1'b0, 16'h0F0F);  // R7
    run_txn(2, 1'b1, 1'b1, 0, 2, 1'b0, 16'h8001);  // R8
    run_txn(0, 1'b0, 1'b1, 0, 0, 1'b0, 16'h5AA5);  // R10 error cleared by start
    run_txn(3, 1'b1, 1'b1, 1, 1, 1'b0, 16'h7E7E);  // R9
    run_txn(0, 1'b1, 1'b0, 0, 0, 1'b1, 16'h3C3C);  // R11
    run_txn(2, 1'b0, 1'b1, 3, 0, 1'b0, 16'hC001);  // R8 after waits
    while (exp_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule